// File: doc/BRIEF.md
# Set-Only Gated Byte Memory

This block is a small memory of eight bytes, each eight bits wide, built from bit cells that a write can only set. Each cell takes a data bit and three control lines: write enable, read enable and an active-low clear. The eight cells of one byte share those three control lines. A controller stage registers each request: the address, a one-byte write buffer and the three control requests. On the next cycle it drives the control lines of the addressed byte only.

A write ORs the buffered byte into the stored byte, so bits already at 1 stay at 1. Driving the clear line low empties the addressed byte. Clear also stops any bit of that byte from being set in the same cycle. The read port returns the addressed byte one clock after the request. When no read is requested, the read port is forced to all zeros, whatever the memory holds. Bit 7 of each byte carries weight 128 and bit 0 carries weight 1, on both the write and the read side.

The block is meant for flag stores or sticky-status tables. In those uses, bits collect over time and are cleared byte by byte under explicit control.

Top module: `setmem_array`

## Requirements
- R1: While `rst_n` is low at a clock edge, every stored bit becomes 0 and `rd_data` becomes 0.
- R2: A request with `wr_en`=1, `clr_n`=1 at address A is applied on the following clock edge. Byte A then holds its old value OR `wr_data` (bit 7 = weight 128).
- R3: A write never turns a stored 1 into 0, whatever `wr_data` holds.
- R4: With `wr_en`=0, no stored bit changes, whatever is on `wr_data`.
- R5: When `rd_en` was 0 at the last clock edge, `rd_data` is all zeros, whatever is stored.
- R6: A read request at address A, sampled at a clock edge, puts byte A on `rd_data` right after that edge. A write applied at the same edge is visible.
- R7: A request with `clr_n`=0 at address A clears byte A to 0 on the following clock edge.
- R8: When `clr_n`=0 and `wr_en`=1 in the same request, clear wins and the byte ends at 0.
- R9: Only the addressed byte is affected by a write or a clear. The other seven keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of all state |
| addr | input | 3 | Byte select for the request |
| wr_data | input | 8 | Byte to OR into the selected entry (captured into the write buffer) |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| clr_n | input | 1 | Active-low clear request for the selected byte |
| rd_data | output | 8 | Selected byte one clock after a read, zero otherwise |

## Verification
The bench layers writes with overlapping bit patterns on one byte. A design that overwrote instead of ORing would lose earlier bits, and one that let a zero data bit clear a cell would show holes. It issues clear together with write, which exposes a wrong priority as surviving bits. It also reads immediately after a write, which catches an off-by-one pipeline that returns stale data. Other checks watch neighbouring bytes after writes and clears to catch address decode faults, and watch `rd_data` during cycles with no read to catch a read path that leaks stored values.

// File: rtl/setmem_pkg.sv
// Package: shared sizing for the set-only byte memory.
// Assumes: depth is a power of two so the address width covers it exactly.
package setmem_pkg;
    localparam int unsigned SM_DATA_W = 8;
    localparam int unsigned SM_ADDR_W = 3;
    localparam int unsigned SM_DEPTH  = 1 << SM_ADDR_W;

    // Registered request held by the controller between the two stages.
    typedef struct packed {
        logic wr;
        logic rd;
        logic clr;
    } sm_req_t;
endpackage

// File: rtl/setmem_bit.sv
// Module: one set-only storage cell.
// Does: sets on write with a 1 data bit, clears while clr_n is low, and
// drives its output only while rd is high.
// Assumes: control lines come from registers in the controller.
module setmem_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    input  logic wr,
    input  logic rd,
    input  logic clr_n,
    output logic q_out
);
    logic q;

    // Storage: clear has priority, a write can only raise the bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (!clr_n)
            q <= 1'b0;
        else if (wr && d)
            q <= 1'b1;
    end

    // Read gate: the output is zero unless the read line is active.
    always_comb q_out = rd & q;

    AST_SET_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> $past(wr && d && clr_n)); // R4
    AST_WRITE_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q) |-> $past(!clr_n)); // R3
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> !q); // R8
endmodule

// File: rtl/setmem_byte.sv
// Module: one byte of set-only cells sharing write, read and clear lines.
// Does: replicates the bit cell DATA_W times; bit DATA_W-1 is the heaviest.
// Assumes: the lines are inactive unless this byte is addressed.
module setmem_byte #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              wr,
    input  logic              rd,
    input  logic              clr_n,
    output logic [DATA_W-1:0] dout
);
    // Cell array: one cell per bit position, all on the shared lines.
    for (genvar b = 0; b < DATA_W; b++) begin : g_cell
        setmem_bit u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (din[b]),
            .wr    (wr),
            .rd    (rd),
            .clr_n (clr_n),
            .q_out (dout[b])
        );
    end
endmodule

// File: rtl/setmem_ctrl.sv
// Module: request controller with the one-byte write buffer.
// Does: registers address, data and control requests, then decodes them
// into per-byte write, read and active-low clear lines for the next cycle.
// Assumes: a clear request is signalled by clr_n low on the input side.
module setmem_ctrl
    import setmem_pkg::*;
#(
    parameter int unsigned DATA_W = SM_DATA_W,
    parameter int unsigned ADDR_W = SM_ADDR_W,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              clr_n,
    output logic [DATA_W-1:0] buf_data,
    output logic [DEPTH-1:0]  wr_line,
    output logic [DEPTH-1:0]  rd_line,
    output logic [DEPTH-1:0]  clr_n_line
);
    logic [ADDR_W-1:0] buf_addr;
    sm_req_t           req_q;

    // Request stage: capture the write buffer, address and controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_data <= '0;
            buf_addr <= '0;
            req_q    <= '0;
        end else begin
            buf_data  <= wr_data;
            buf_addr  <= addr;
            req_q.wr  <= wr_en;
            req_q.rd  <= rd_en;
            req_q.clr <= ~clr_n;
        end
    end

    // Line decode: only the buffered address gets active lines.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            wr_line[i]    = req_q.wr  && (buf_addr == ADDR_W'(i));
            rd_line[i]    = req_q.rd  && (buf_addr == ADDR_W'(i));
            clr_n_line[i] = !(req_q.clr && (buf_addr == ADDR_W'(i)));
        end
    end
endmodule

// File: rtl/setmem_array.sv
// Module: top of the set-only byte memory.
// Does: a controller stage followed by DEPTH bytes; the read port ORs the
// gated byte outputs, so it is zero whenever no byte's read line is high.
// Assumes: one request per cycle, results one clock after the request.
module setmem_array
    import setmem_pkg::*;
#(
    parameter int unsigned DATA_W = SM_DATA_W,
    parameter int unsigned ADDR_W = SM_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              clr_n,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] buf_data;
    logic [DEPTH-1:0]  wr_line;
    logic [DEPTH-1:0]  rd_line;
    logic [DEPTH-1:0]  clr_n_line;
    logic [DATA_W-1:0] byte_out [DEPTH];

    setmem_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .wr_data    (wr_data),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .clr_n      (clr_n),
        .buf_data   (buf_data),
        .wr_line    (wr_line),
        .rd_line    (rd_line),
        .clr_n_line (clr_n_line)
    );

    // Byte array: every byte sees the write buffer and its own lines.
    for (genvar e = 0; e < DEPTH; e++) begin : g_byte
        setmem_byte #(.DATA_W(DATA_W)) u_byte (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (buf_data),
            .wr    (wr_line[e]),
            .rd    (rd_line[e]),
            .clr_n (clr_n_line[e]),
            .dout  (byte_out[e])
        );
    end

    // Read merge: OR of gated outputs; at most one byte is enabled.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++)
            rd_data = rd_data | byte_out[i];
    end

    AST_READ_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> rd_data == '0); // R5
    AST_ONE_WRITE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_line)); // R9
    AST_ONE_CLEAR_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~clr_n_line) <= 1); // R7
endmodule

// File: tb/test_setmem_array.sv
module test_setmem_array;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       clr_n = 1'b1;
    logic [7:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] model [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    setmem_array i_setmem_array (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .clr_n(clr_n), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
        end
    endtask

    // One request cycle: drive after negedge, capture at posedge, back to idle.
    task automatic op(input logic [2:0] a, input logic [7:0] d,
                      input logic w, input logic r, input logic c);
        addr = a; wr_data = d; wr_en = w; rd_en = r; clr_n = c;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; clr_n = 1'b1;
    endtask

    task automatic rd_check(input logic [2:0] a, input string req);
        op(a, 8'h00, 1'b0, 1'b1, 1'b1);
        check(req, rd_data, model[a]);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 rd_data after reset", rd_data, 8'h00);
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        rd_check(3'd0, "R1 byte0 empty");
        rd_check(3'd7, "R1 byte7 empty");
    endtask

    task automatic t_write_or;
        op(3'd2, 8'hA0, 1'b1, 1'b0, 1'b1); model[2] |= 8'hA0;
        rd_check(3'd2, "R2 first write");
        op(3'd2, 8'h05, 1'b1, 1'b0, 1'b1); model[2] |= 8'h05;
        rd_check(3'd2, "R2 OR of second write");
        op(3'd2, 8'h00, 1'b1, 1'b0, 1'b1);
        rd_check(3'd2, "R3 zero write keeps ones");
        op(3'd2, 8'h5A, 1'b1, 1'b0, 1'b1); model[2] |= 8'h5A;
        rd_check(3'd2, "R3 overlapping write");
        op(3'd5, 8'h80, 1'b1, 1'b0, 1'b1); model[5] |= 8'h80;
        rd_check(3'd5, "R2 bit7 weight 128");
    endtask

    task automatic t_no_write;
        op(3'd4, 8'hFF, 1'b0, 1'b0, 1'b1);
        rd_check(3'd4, "R4 data without write");
    endtask

    task automatic t_read_off;
        op(3'd2, 8'h00, 1'b0, 1'b1, 1'b1);
        check("R6 read shows byte", rd_data, model[2]);
        op(3'd2, 8'h00, 1'b0, 1'b0, 1'b1);
        check("R5 read off gives zero", rd_data, 8'h00);
        op(3'd5, 8'h01, 1'b1, 1'b0, 1'b1); model[5] |= 8'h01;
        check("R5 zero during write", rd_data, 8'h00);
    endtask

    task automatic t_write_then_read;
        addr = 3'd6; wr_data = 8'h3C; wr_en = 1'b1; rd_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        model[6] |= 8'h3C;
        wr_en = 1'b0; rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        check("R6 back-to-back read", rd_data, model[6]);
    endtask

    task automatic t_clear;
        op(3'd1, 8'hFF, 1'b1, 1'b0, 1'b1); model[1] = 8'hFF;
        op(3'd2, 8'h00, 1'b0, 1'b0, 1'b0); model[2] = 8'h00;
        rd_check(3'd2, "R7 cleared byte");
        rd_check(3'd1, "R9 neighbour kept on clear");
        rd_check(3'd5, "R9 other byte kept");
    endtask

    task automatic t_clear_priority;
        op(3'd1, 8'hFF, 1'b1, 1'b0, 1'b0); model[1] = 8'h00;
        rd_check(3'd1, "R8 clear beats write");
        op(3'd1, 8'h11, 1'b1, 1'b0, 1'b1); model[1] = 8'h11;
        rd_check(3'd1, "R2 write after clear");
    endtask

    task automatic t_isolation;
        op(3'd0, 8'hC3, 1'b1, 1'b0, 1'b1); model[0] |= 8'hC3;
        for (int i = 0; i < 8; i++) rd_check(3'(i), "R9 per-byte isolation");
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_write_or();
        t_no_write();
        t_read_off();
        t_write_then_read();
        t_clear();
        t_clear_priority();
        t_isolation();
        t_reset();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule